// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which low-power state the processor enters when it stops to wait, and it runs that state until a qualifying wake source arrives. Three configuration bits choose the state. The deep-sleep flag picks between a light state and the deep states. Within the deep states, the power-down select bit picks between clock stop and domain power-off. The low-power-regulator bit chooses the regulator used while clocks are stopped.

The light state (Sleep) gates only the core clock. The clock-stop state (Stop) halts all clocks and keeps state. The power-off state (Standby) removes power from the core domain, so a wake from it behaves as a reset. Each state has its own set of wake sources and its own actions on exit:
- Leaving Stop hands the system clock to the internal RC oscillator.
- If Stop ran on the low-power regulator, leaving it first waits a programmable warm-up count.
- Leaving Standby pulses a reset output and sets a sticky flag.

The sequencer also re-enters low power automatically when interrupt handling finishes, if sleep-on-exit is set. It keeps an event latch for wait-for-event requests, and it can treat a newly pending interrupt as an event.

Top module: `lp_mode_seq`

## Requirements
- R1: With `deep_sleep`=0, a `wfi_req` pulse makes `core_clk_off`=1 from the next cycle, with `sys_clk_stop`, `pd_off` and `reg_lowpower` at 0. `irq_take` returns the block to run in the following cycle and sets `woke_from`=1.
- R2: With `deep_sleep`=1 and `pdown_sel`=0, a wait request sets both `core_clk_off` and `sys_clk_stop` with `pd_off`=0. `reg_lowpower` follows the value of `lp_reg_sel` captured at entry; later changes to that input are ignored.
- R3: Stop is left only when a line has `exti_evt` and `exti_en` set at the same bit position, or when `serial_wake` is high. `irq_take`, and event lines with a clear enable, have no effect.
- R4: With `deep_sleep`=1 and `pdown_sel`=1, a wait request sets `pd_off`, `sys_clk_stop` and `core_clk_off`. Only the following leave this state:
  - a rising edge on a `wkup_pin` bit whose `wkup_en` bit is set (a pin already high at entry does not wake);
  - `rtc_evt`;
  - `ext_rst_req`;
  - `wdog_rst_req`.
- R5: A Stop entered with the low-power regulator keeps `sys_clk_stop` high for `warm_cycles`+1 cycles after the wake cycle before run resumes. With the normal regulator, run resumes in the next cycle.
- R6: On each return to run from Stop, `clk_to_rc` is high for exactly the first run cycle, and `woke_from` becomes 2.
- R7: A wake from Standby gives a one-cycle `wake_reset` pulse, sets `woke_from`=3 and sets `standby_flag`. The flag stays set until `sb_flag_clr`. When a Standby wake and a clear fall in the same cycle, the set wins.
- R8: With `sleep_on_exit`=1, an `isr_exit` pulse in run enters the mode selected by the configuration bits, as a wait-for-interrupt would. With `sleep_on_exit`=0, `isr_exit` is ignored.
- R9: An `event_in` pulse sets an event latch. A `wfe_req` that finds the latch set keeps the block running and clears the latch; the next `wfe_req` then sleeps. A Sleep entered by `wfe_req` also wakes on `event_in`.
- R10: With `sev_on_pend`=1, a 0-to-1 change on any bit of `irq_pend` counts as an event: it wakes a wait-for-event Sleep or sets the latch. With `sev_on_pend`=0, such changes have no effect.
- R11: After reset, all control outputs, `wake_reset`, `clk_to_rc` and `standby_flag` are 0, and `woke_from` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wfi_req | input | 1 | Wait-for-interrupt request pulse |
| wfe_req | input | 1 | Wait-for-event request pulse |
| isr_exit | input | 1 | Pulse when interrupt handling returns to thread level |
| deep_sleep | input | 1 | Selects the deep states over Sleep |
| pdown_sel | input | 1 | In deep states, selects Standby over Stop |
| lp_reg_sel | input | 1 | Selects the low-power regulator in Stop |
| sleep_on_exit | input | 1 | Re-enter low power when interrupt handling ends |
| sev_on_pend | input | 1 | Newly pending interrupt counts as an event |
| warm_cycles | input | CW | Warm-up count after a low-power-regulator Stop |
| irq_take | input | 1 | An enabled interrupt is ready to be taken |
| irq_pend | input | NIRQ | Pending state of each interrupt line |
| event_in | input | 1 | External event pulse |
| exti_evt | input | NEXTI | External interrupt line events |
| exti_en | input | NEXTI | Per-line enables for the external lines |
| serial_wake | input | 1 | Wake-capable serial peripheral interrupt |
| wkup_pin | input | NPIN | Wakeup pin levels |
| wkup_en | input | NPIN | Per-pin wakeup enables |
| rtc_evt | input | 1 | RTC alarm, timer, tamper or time-stamp event |
| ext_rst_req | input | 1 | External reset request |
| wdog_rst_req | input | 1 | Watchdog reset request |
| sb_flag_clr | input | 1 | Software clear of the standby flag |
| core_clk_off | output | 1 | Core clock gated |
| sys_clk_stop | output | 1 | System clocks stopped |
| reg_lowpower | output | 1 | Regulator in low-power mode |
| pd_off | output | 1 | Core power domain off |
| clk_to_rc | output | 1 | One-cycle request to switch system clock to internal RC |
| wake_reset | output | 1 | One-cycle reset pulse after a Standby wake |
| standby_flag | output | 1 | Sticky: woke from Standby |
| woke_from | output | 2 | Last wake: 0 none, 1 Sleep, 2 Stop, 3 Standby |

## Verification
The case of interest is a Standby wake and a software clear of the standby flag arriving in the same cycle. The wake tries to set the flag while the clear tries to drop it. The bench enters Standby with the flag already set. It then raises `rtc_evt` and `sb_flag_clr` together, and it requires the flag to read 1 in the cycle of the reset pulse. A clear issued alone afterwards must then drop the flag to 0. A second overlap is a `wfe_req` landing on a set event latch: the request must be consumed without any clock gating.

// File: rtl/lpm_pkg.sv
// Package: shared state and wake-source codes for the low-power sequencer.
// Assumes: states are only ever compared by name; the encodings are not decoded outside.
package lpm_pkg;
    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_SLEEP = 3'd1,
        ST_STOP  = 3'd2,
        ST_STBY  = 3'd3,
        ST_WARM  = 3'd4
    } lpm_state_t;

    typedef enum logic [1:0] {
        WK_NONE  = 2'd0,
        WK_SLEEP = 2'd1,
        WK_STOP  = 2'd2,
        WK_STBY  = 2'd3
    } wake_src_t;
endpackage

// File: rtl/lpm_mode_select.sv
// Module: picks the low-power state a wait request will enter.
// Assumes: configuration bits are stable in the cycle of the request.
module lpm_mode_select
    import lpm_pkg::*;
(
    input  logic       deep_sleep,
    input  logic       pdown_sel,
    output lpm_state_t target
);
    // Purpose: map the deep-sleep and power-down bits to a target state.
    always_comb begin
        if (!deep_sleep)
            target = ST_SLEEP;
        else if (pdown_sel)
            target = ST_STBY;
        else
            target = ST_STOP;
    end
endmodule

// File: rtl/lpm_wake_qual.sv
// Module: qualifies wake sources for each low-power state and builds the event strobe.
// Assumes: all inputs are synchronous to clk; pin and pending edges are seen
// against the previous cycle's sampled level.
module lpm_wake_qual #(
    parameter int NIRQ  = 8,
    parameter int NEXTI = 16,
    parameter int NPIN  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIRQ-1:0]  irq_pend,
    input  logic             sev_on_pend,
    input  logic             event_in,
    input  logic [NEXTI-1:0] exti_evt,
    input  logic [NEXTI-1:0] exti_en,
    input  logic             serial_wake,
    input  logic [NPIN-1:0]  wkup_pin,
    input  logic [NPIN-1:0]  wkup_en,
    input  logic             rtc_evt,
    input  logic             ext_rst_req,
    input  logic             wdog_rst_req,
    output logic             evt_now,
    output logic             stop_wake,
    output logic             stby_wake
);
    logic [NIRQ-1:0] pend_q;
    logic [NPIN-1:0] pin_q;
    logic [NPIN-1:0] pin_hit;

    // Purpose: remember last-cycle pending and pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            pin_q  <= '0;
        end else begin
            pend_q <= irq_pend;
            pin_q  <= wkup_pin;
        end
    end

    // One rising-edge qualifier per wakeup pin, gated by its own enable.
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        assign pin_hit[g] = wkup_en[g] & wkup_pin[g] & ~pin_q[g];
    end

    // Purpose: combine sources into the three wake strobes.
    always_comb begin
        evt_now   = event_in | (sev_on_pend & |(irq_pend & ~pend_q));
        stop_wake = |(exti_evt & exti_en) | serial_wake;
        stby_wake = |pin_hit | rtc_evt | ext_rst_req | wdog_rst_req;
    end
endmodule

// File: rtl/lpm_warm_timer.sv
// Module: counts regulator warm-up cycles after a low-power-regulator stop.
// Assumes: load is only raised while idle; done lasts one cycle per load.
module lpm_warm_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic          busy;
    logic [CW-1:0] cnt;

    // Purpose: load the count, then step down to zero and go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            cnt  <= load_val;
        end else if (busy) begin
            if (cnt == '0)
                busy <= 1'b0;
            else
                cnt <= cnt - 1'b1;
        end
    end

    assign done = busy && (cnt == '0);

    AST_WARM_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1)); // R5
    AST_WARM_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> !busy); // R5
endmodule

// File: rtl/lp_mode_seq.sv
// Module: low-power mode sequencer top. Enters Sleep, Stop or Standby on a wait
// request or on sleep-on-exit, and leaves on the wake sources each state allows.
// Assumes: request inputs are single-cycle pulses; configuration bits are plain
// inputs; the regulator choice is captured at entry to Stop.
module lp_mode_seq
    import lpm_pkg::*;
#(
    parameter int NIRQ  = 8,
    parameter int NEXTI = 16,
    parameter int NPIN  = 8,
    parameter int CW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wfi_req,
    input  logic             wfe_req,
    input  logic             isr_exit,
    input  logic             deep_sleep,
    input  logic             pdown_sel,
    input  logic             lp_reg_sel,
    input  logic             sleep_on_exit,
    input  logic             sev_on_pend,
    input  logic [CW-1:0]    warm_cycles,
    input  logic             irq_take,
    input  logic [NIRQ-1:0]  irq_pend,
    input  logic             event_in,
    input  logic [NEXTI-1:0] exti_evt,
    input  logic [NEXTI-1:0] exti_en,
    input  logic             serial_wake,
    input  logic [NPIN-1:0]  wkup_pin,
    input  logic [NPIN-1:0]  wkup_en,
    input  logic             rtc_evt,
    input  logic             ext_rst_req,
    input  logic             wdog_rst_req,
    input  logic             sb_flag_clr,
    output logic             core_clk_off,
    output logic             sys_clk_stop,
    output logic             reg_lowpower,
    output logic             pd_off,
    output logic             clk_to_rc,
    output logic             wake_reset,
    output logic             standby_flag,
    output logic [1:0]       woke_from
);
    lpm_state_t state;
    lpm_state_t target;
    wake_src_t  woke_q;
    logic       lp_q;
    logic       wfe_q;
    logic       evt_latch;
    logic       evt_now, stop_wake, stby_wake;
    logic       warm_load, warm_done;
    logic       soe_hit, wfe_sleep, enter_any, stby_hit;

    lpm_mode_select u_sel (
        .deep_sleep (deep_sleep),
        .pdown_sel  (pdown_sel),
        .target     (target)
    );

    lpm_wake_qual #(.NIRQ(NIRQ), .NEXTI(NEXTI), .NPIN(NPIN)) u_wake (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_pend     (irq_pend),
        .sev_on_pend  (sev_on_pend),
        .event_in     (event_in),
        .exti_evt     (exti_evt),
        .exti_en      (exti_en),
        .serial_wake  (serial_wake),
        .wkup_pin     (wkup_pin),
        .wkup_en      (wkup_en),
        .rtc_evt      (rtc_evt),
        .ext_rst_req  (ext_rst_req),
        .wdog_rst_req (wdog_rst_req),
        .evt_now      (evt_now),
        .stop_wake    (stop_wake),
        .stby_wake    (stby_wake)
    );

    lpm_warm_timer #(.CW(CW)) u_warm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (warm_load),
        .load_val (warm_cycles),
        .done     (warm_done)
    );

    // Purpose: decode entry triggers and per-state exit triggers.
    always_comb begin
        soe_hit   = sleep_on_exit & isr_exit;
        wfe_sleep = wfe_req & ~evt_latch;
        enter_any = (state == ST_RUN) & (wfi_req | wfe_sleep | soe_hit);
        stby_hit  = (state == ST_STBY) & stby_wake;
        warm_load = (state == ST_STOP) & stop_wake & lp_q;
    end

    // Purpose: mode state machine with registered exit pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_RUN;
            lp_q       <= 1'b0;
            wfe_q      <= 1'b0;
            woke_q     <= WK_NONE;
            clk_to_rc  <= 1'b0;
            wake_reset <= 1'b0;
        end else begin
            clk_to_rc  <= 1'b0;
            wake_reset <= 1'b0;
            case (state)
                ST_RUN: begin
                    if (enter_any) begin
                        state <= target;
                        lp_q  <= lp_reg_sel;
                        wfe_q <= wfe_sleep & ~wfi_req & ~soe_hit;
                    end
                end
                ST_SLEEP: begin
                    if (irq_take || (wfe_q && evt_now)) begin
                        state  <= ST_RUN;
                        woke_q <= WK_SLEEP;
                    end
                end
                ST_STOP: begin
                    if (stop_wake) begin
                        woke_q <= WK_STOP;
                        if (lp_q) begin
                            state <= ST_WARM;
                        end else begin
                            state     <= ST_RUN;
                            clk_to_rc <= 1'b1;
                        end
                    end
                end
                ST_WARM: begin
                    if (warm_done) begin
                        state     <= ST_RUN;
                        clk_to_rc <= 1'b1;
                    end
                end
                ST_STBY: begin
                    if (stby_wake) begin
                        state      <= ST_RUN;
                        wake_reset <= 1'b1;
                        woke_q     <= WK_STBY;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    // Purpose: sticky standby flag; a wake in the same cycle beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            standby_flag <= 1'b0;
        else if (stby_hit)
            standby_flag <= 1'b1;
        else if (sb_flag_clr)
            standby_flag <= 1'b0;
    end

    // Purpose: event latch; set by events except the one ending a WFE sleep,
    // consumed by a WFE in run, wiped by the reset that follows Standby.
    always_ff @(posedge clk) begin
        if (!rst_n || stby_hit)
            evt_latch <= 1'b0;
        else
            evt_latch <= (evt_now & ~((state == ST_SLEEP) & wfe_q))
                       | (evt_latch & ~((state == ST_RUN) & wfe_req));
    end

    // Purpose: drive clock and power controls from the current state.
    always_comb begin
        core_clk_off = (state != ST_RUN);
        sys_clk_stop = (state == ST_STOP) || (state == ST_STBY) || (state == ST_WARM);
        pd_off       = (state == ST_STBY);
        reg_lowpower = (state == ST_STOP) && lp_q;
        woke_from    = woke_q;
    end

    AST_STANDBY_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pd_off |-> (sys_clk_stop && core_clk_off)); // R4
    AST_SYSSTOP_GATES_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_clk_stop |-> core_clk_off); // R2
    AST_LPREG_ONLY_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_lowpower |-> (sys_clk_stop && !pd_off)); // R2
    AST_RC_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        clk_to_rc |-> (!core_clk_off && $past(sys_clk_stop) && !$past(pd_off))); // R6
    AST_RC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        clk_to_rc |=> !clk_to_rc); // R6
    AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_reset |=> !wake_reset); // R7
    AST_FLAG_WITH_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        wake_reset |-> (standby_flag && woke_from == 2'd3 && $past(pd_off))); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(standby_flag) && !$past(sb_flag_clr)) |-> standby_flag); // R7
endmodule

// File: tb/lp_mode_seq_test.sv
`timescale 1ns/1ps
module lp_mode_seq_test;
    localparam int NIRQ = 8, NEXTI = 16, NPIN = 8, CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wfi_req = 0, wfe_req = 0, isr_exit = 0;
    logic deep_sleep = 0, pdown_sel = 0, lp_reg_sel = 0;
    logic sleep_on_exit = 0, sev_on_pend = 0;
    logic [CW-1:0] warm_cycles = '0;
    logic irq_take = 0;
    logic [NIRQ-1:0] irq_pend = '0;
    logic event_in = 0;
    logic [NEXTI-1:0] exti_evt = '0, exti_en = '0;
    logic serial_wake = 0;
    logic [NPIN-1:0] wkup_pin = '0, wkup_en = '0;
    logic rtc_evt = 0, ext_rst_req = 0, wdog_rst_req = 0, sb_flag_clr = 0;
    logic core_clk_off, sys_clk_stop, reg_lowpower, pd_off;
    logic clk_to_rc, wake_reset, standby_flag;
    logic [1:0] woke_from;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    lp_mode_seq #(.NIRQ(NIRQ), .NEXTI(NEXTI), .NPIN(NPIN), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
        .isr_exit(isr_exit), .deep_sleep(deep_sleep), .pdown_sel(pdown_sel),
        .lp_reg_sel(lp_reg_sel), .sleep_on_exit(sleep_on_exit),
        .sev_on_pend(sev_on_pend), .warm_cycles(warm_cycles), .irq_take(irq_take),
        .irq_pend(irq_pend), .event_in(event_in), .exti_evt(exti_evt),
        .exti_en(exti_en), .serial_wake(serial_wake), .wkup_pin(wkup_pin),
        .wkup_en(wkup_en), .rtc_evt(rtc_evt), .ext_rst_req(ext_rst_req),
        .wdog_rst_req(wdog_rst_req), .sb_flag_clr(sb_flag_clr),
        .core_clk_off(core_clk_off), .sys_clk_stop(sys_clk_stop),
        .reg_lowpower(reg_lowpower), .pd_off(pd_off), .clk_to_rc(clk_to_rc),
        .wake_reset(wake_reset), .standby_flag(standby_flag), .woke_from(woke_from)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_wfi();
        wfi_req = 1; step(); wfi_req = 0;
    endtask

    task automatic t_reset();
        chk("R11", "core_clk_off", core_clk_off, 0);
        chk("R11", "sys_clk_stop", sys_clk_stop, 0);
        chk("R11", "pd_off", pd_off, 0);
        chk("R11", "reg_lowpower", reg_lowpower, 0);
        chk("R11", "clk_to_rc", clk_to_rc, 0);
        chk("R11", "wake_reset", wake_reset, 0);
        chk("R11", "standby_flag", standby_flag, 0);
        chk("R11", "woke_from", woke_from, 0);
    endtask

    task automatic t_sleep_wfi();
        deep_sleep = 0;
        pulse_wfi();
        chk("R1", "sleep core_clk_off", core_clk_off, 1);
        chk("R1", "sleep sys_clk_stop", sys_clk_stop, 0);
        chk("R1", "sleep pd_off", pd_off, 0);
        chk("R1", "sleep reg_lowpower", reg_lowpower, 0);
        irq_take = 1; step(); irq_take = 0;
        chk("R1", "sleep woke core_clk_off", core_clk_off, 0);
        chk("R1", "sleep woke_from", woke_from, 1);
    endtask

    task automatic t_stop_normal();
        deep_sleep = 1; pdown_sel = 0; lp_reg_sel = 0;
        pulse_wfi();
        chk("R2", "stop sys_clk_stop", sys_clk_stop, 1);
        chk("R2", "stop core_clk_off", core_clk_off, 1);
        chk("R2", "stop pd_off", pd_off, 0);
        chk("R2", "stop reg_lowpower", reg_lowpower, 0);
        irq_take = 1; exti_evt[3] = 1; exti_en[3] = 0; step();
        irq_take = 0; exti_evt[3] = 0;
        chk("R3", "stop ignores irq/disabled line", sys_clk_stop, 1);
        exti_en[3] = 1; exti_evt[3] = 1; step(); exti_evt[3] = 0;
        chk("R3", "stop woke on enabled line", core_clk_off, 0);
        chk("R6", "clk_to_rc first run cycle", clk_to_rc, 1);
        chk("R6", "woke_from stop", woke_from, 2);
        step();
        chk("R6", "clk_to_rc one cycle", clk_to_rc, 0);
        exti_en = '0;
    endtask

    task automatic t_stop_lowreg();
        deep_sleep = 1; pdown_sel = 0; lp_reg_sel = 1; warm_cycles = 8'd3;
        pulse_wfi();
        chk("R2", "lowreg reg_lowpower", reg_lowpower, 1);
        lp_reg_sel = 0; step();
        chk("R2", "reg choice held from entry", reg_lowpower, 1);
        serial_wake = 1; step(); serial_wake = 0;
        for (int i = 0; i < 4; i++) begin
            chk("R5", "warm-up clocks stopped", sys_clk_stop, 1);
            chk("R5", "warm-up no rc switch yet", clk_to_rc, 0);
            step();
        end
        chk("R5", "warm-up over", sys_clk_stop, 0);
        chk("R6", "rc after warm-up", clk_to_rc, 1);
        step();
    endtask

    task automatic t_standby();
        deep_sleep = 1; pdown_sel = 1;
        wkup_en = 8'b0000_0010; wkup_pin[1] = 1; step(); step();
        pulse_wfi();
        chk("R4", "standby pd_off", pd_off, 1);
        chk("R4", "standby sys_clk_stop", sys_clk_stop, 1);
        irq_take = 1; serial_wake = 1; exti_en[0] = 1; exti_evt[0] = 1; step();
        irq_take = 0; serial_wake = 0; exti_en[0] = 0; exti_evt[0] = 0;
        chk("R4", "standby ignores stop sources", pd_off, 1);
        wkup_pin[2] = 1; step();
        chk("R4", "disabled pin edge ignored, high pin no wake", pd_off, 1);
        wkup_pin[1] = 0; step();
        chk("R4", "falling pin ignored", pd_off, 1);
        wkup_pin[1] = 1; step();
        chk("R4", "pin edge woke", pd_off, 0);
        chk("R7", "wake_reset pulse", wake_reset, 1);
        chk("R7", "standby_flag set", standby_flag, 1);
        chk("R7", "woke_from standby", woke_from, 3);
        step();
        chk("R7", "wake_reset one cycle", wake_reset, 0);
        chk("R7", "flag sticky", standby_flag, 1);
        wkup_pin = '0; wkup_en = '0;
    endtask

    task automatic t_flag_race();
        deep_sleep = 1; pdown_sel = 1;
        pulse_wfi();
        chk("R4", "standby again", pd_off, 1);
        rtc_evt = 1; sb_flag_clr = 1; step(); rtc_evt = 0; sb_flag_clr = 0;
        chk("R7", "set beats clear", standby_flag, 1);
        chk("R7", "rtc wake reset", wake_reset, 1);
        sb_flag_clr = 1; step(); sb_flag_clr = 0;
        chk("R7", "clear alone", standby_flag, 0);
        pulse_wfi();
        wdog_rst_req = 1; step(); wdog_rst_req = 0;
        chk("R4", "watchdog wakes standby", pd_off, 0);
        sb_flag_clr = 1; step(); sb_flag_clr = 0;
    endtask

    task automatic t_sleep_on_exit();
        deep_sleep = 0; pdown_sel = 0;
        sleep_on_exit = 0; isr_exit = 1; step(); isr_exit = 0;
        chk("R8", "isr_exit ignored when off", core_clk_off, 0);
        sleep_on_exit = 1; isr_exit = 1; step(); isr_exit = 0;
        chk("R8", "isr_exit enters sleep", core_clk_off, 1);
        chk("R8", "isr_exit chose sleep", sys_clk_stop, 0);
        irq_take = 1; step(); irq_take = 0;
        chk("R8", "woke after sleep-on-exit", core_clk_off, 0);
        sleep_on_exit = 0;
    endtask

    task automatic t_wfe_latch();
        deep_sleep = 0;
        event_in = 1; step(); event_in = 0;
        wfe_req = 1; step(); wfe_req = 0;
        chk("R9", "wfe with latch stays running", core_clk_off, 0);
        wfe_req = 1; step(); wfe_req = 0;
        chk("R9", "second wfe sleeps", core_clk_off, 1);
        step();
        event_in = 1; step(); event_in = 0;
        chk("R9", "event wakes wfe sleep", core_clk_off, 0);
        chk("R9", "woke_from sleep", woke_from, 1);
    endtask

    task automatic t_sev_on_pend();
        deep_sleep = 0; sev_on_pend = 0;
        wfe_req = 1; step(); wfe_req = 0;
        chk("R10", "wfe sleep entered", core_clk_off, 1);
        irq_pend[2] = 1; step();
        chk("R10", "pend edge ignored without sev", core_clk_off, 1);
        sev_on_pend = 1; irq_pend[5] = 1; step();
        chk("R10", "pend edge wakes with sev", core_clk_off, 0);
        irq_pend[6] = 1; step();
        wfe_req = 1; step(); wfe_req = 0;
        chk("R10", "pend edge latched as event", core_clk_off, 0);
        irq_pend = '0; sev_on_pend = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1;
        step();
        t_reset();
        t_sleep_wfi();
        t_stop_normal();
        t_stop_lowreg();
        t_standby();
        t_flag_race();
        t_sleep_on_exit();
        t_wfe_latch();
        t_sev_on_pend();
        step();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule